// File: doc/BRIEF.md
# ECC Error Capture Logger

This block sits beside a DRAM controller and watches its error strobes for correctable (single-bit) and uncorrectable (double-bit) ECC events. When the first such event arrives, it captures the context of the failing access: whether the memory scrubber or the local CPU bus master made it, the level of the bus read line, whether a non-primary bus master was driving the bus, the top address byte, and whether the error was single-bit or double-bit. The record then stays frozen until software acknowledges it.

Software reaches the record through a small register port. Offset 0 is a status word, and offset 1 holds the captured address byte. The valid flag in the status word is cleared by writing one to it. A peer-clear input lets two copies of the block, one per memory half, share a single software clear. Either instance's clearing write is routed to the other instance's `peer_clr`.

Top module: `ecc_err_logger`

## Requirements
- R1: After a synchronous active-high reset, the status word (offset 0) and the address register (offset 1) both read 0.
- R2: Status bit 0 (logged) is set only by an error event while it is clear. No register write sets it, including writes of one to any status bit.
- R3: Writing a word with bit 0 = 1 to offset 0 clears the logged bit at the next clock edge. Writing bit 0 = 0 leaves it unchanged. The other captured fields keep their values after the clear.
- R4: While logged is set, further error events are ignored, and every captured field (status bits 1–4 and the address register) keeps its value.
- R5: On capture, status bit 1 (scrub) stores 1 if the scrubber made the access and 0 if the CPU made it.
- R6: On capture, status bit 2 (read) stores the level of the read line for CPU accesses. It is stored as 0 when the scrubber made the access.
- R7: On capture, status bit 3 (alternate) is set exactly when the primary-master indicator `ctx_main` was low.
- R8: On capture, address bits 31–24 are stored at offset 1. This register is read-only: writes to it are ignored.
- R9: A high `peer_clr` clears the logged bit at the next clock edge, the same as a software clear.
- R10: If an error event and a clear (write or `peer_clr`) occur in the same cycle, the clear wins and the event is dropped. The next event after that is logged normally.
- R11: On capture, status bit 4 (double) is 1 for a double-bit event and 0 for a single-bit event. If both strobes are high together, it is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_err | input | 1 | Single-bit error strobe |
| db_err | input | 1 | Double-bit error strobe |
| ctx_scrub | input | 1 | Access made by scrubber (1) or CPU (0) |
| ctx_rd | input | 1 | Level of the bus read line |
| ctx_main | input | 1 | Primary bus master asserted |
| ctx_addr | input | EAW | Address bits 31–24 of the access |
| peer_clr | input | 1 | Clear from the paired instance |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |

## Verification
The capture path is driven with three kinds of access: a CPU single-bit read from the primary master, a scrubber double-bit access from an alternate master, and a CPU access with both strobes raised. Together these separate each context bit from its neighbours, expose any leak of the read level into scrubber records, and show the double-bit priority. Events and writes are also applied while a record is held, to show that nothing moves. Clears are then placed in the same cycle as an event, first through the register port and then through `peer_clr`, to show that the clear wins and that a later event still logs.

// File: rtl/ecc_err_logger.sv
module ecc_err_logger #(
  parameter int AW  = 2,
  parameter int DW  = 8,
  parameter int EAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sb_err,
  input  logic           db_err,
  input  logic           ctx_scrub,
  input  logic           ctx_rd,
  input  logic           ctx_main,
  input  logic [EAW-1:0] ctx_addr,
  input  logic           peer_clr,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata
);
  localparam logic [AW-1:0] STAT_OFS = AW'(0);
  localparam logic [AW-1:0] ADDR_OFS = AW'(1);
  localparam logic [DW-1:0] W1C_MASK = DW'(1);

  logic           log_q, scrub_q, rd_q, alt_q, dbl_q;
  logic [EAW-1:0] addr_q;
  logic           clr_req, take;

  assign clr_req = peer_clr ||
                   (reg_wr && reg_addr == STAT_OFS && |(reg_wdata & W1C_MASK));
  assign take    = (sb_err || db_err) && !log_q && !clr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      log_q   <= 1'b0;
      scrub_q <= 1'b0;
      rd_q    <= 1'b0;
      alt_q   <= 1'b0;
      dbl_q   <= 1'b0;
      addr_q  <= '0;
    end else if (clr_req) begin
      log_q <= 1'b0;
    end else if (take) begin
      log_q   <= 1'b1;
      scrub_q <= ctx_scrub;
      rd_q    <= ctx_rd && !ctx_scrub;
      alt_q   <= !ctx_main;
      dbl_q   <= db_err;
      addr_q  <= ctx_addr;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_OFS) begin
      reg_rdata[0] = log_q;
      reg_rdata[1] = scrub_q;
      reg_rdata[2] = rd_q;
      reg_rdata[3] = alt_q;
      reg_rdata[4] = dbl_q;
    end else if (reg_addr == ADDR_OFS) begin
      reg_rdata[EAW-1:0] = addr_q;
    end
  end
endmodule

module ecc_err_logger_chk #(
  parameter int AW  = 2,
  parameter int EAW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           sb_err,
  input logic           db_err,
  input logic           ctx_scrub,
  input logic           ctx_rd,
  input logic           ctx_main,
  input logic [EAW-1:0] ctx_addr,
  input logic           peer_clr,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic           wr_bit0,
  input logic           log_q,
  input logic           scrub_q,
  input logic           rd_q,
  input logic           alt_q,
  input logic           dbl_q,
  input logic [EAW-1:0] addr_q
);
  logic clr_seen, ev;
  assign clr_seen = peer_clr || (reg_wr && reg_addr == '0 && wr_bit0);
  assign ev       = sb_err || db_err;

  a_r2_set_needs_event: assert property (@(posedge clk) disable iff (rst)
    $rose(log_q) |-> $past(ev));
  a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (rst)
    clr_seen |=> !log_q);
  a_r4_frozen_when_logged: assert property (@(posedge clk) disable iff (rst)
    (log_q && !clr_seen) |=> log_q && $stable(scrub_q) && $stable(rd_q) &&
                             $stable(alt_q) && $stable(dbl_q) && $stable(addr_q));
  a_r5_scrub_captured: assert property (@(posedge clk) disable iff (rst)
    (!log_q && ev && !clr_seen) |=> scrub_q == $past(ctx_scrub));
  a_r6_rd_zero_for_scrub: assert property (@(posedge clk) disable iff (rst)
    (!log_q && ev && !clr_seen && ctx_scrub) |=> !rd_q);
  a_r6_rd_cpu: assert property (@(posedge clk) disable iff (rst)
    (!log_q && ev && !clr_seen && !ctx_scrub) |=> rd_q == $past(ctx_rd));
  a_r7_alt_captured: assert property (@(posedge clk) disable iff (rst)
    (!log_q && ev && !clr_seen) |=> alt_q == !$past(ctx_main));
  a_r8_addr_captured: assert property (@(posedge clk) disable iff (rst)
    (!log_q && ev && !clr_seen) |=> addr_q == $past(ctx_addr));
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (!log_q && ev && clr_seen) |=> !log_q);
  a_r11_double_priority: assert property (@(posedge clk) disable iff (rst)
    (!log_q && db_err && !clr_seen) |=> log_q && dbl_q);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.AW(AW), .EAW(EAW)) u_chk (
  .clk(clk), .rst(rst), .sb_err(sb_err), .db_err(db_err),
  .ctx_scrub(ctx_scrub), .ctx_rd(ctx_rd), .ctx_main(ctx_main),
  .ctx_addr(ctx_addr), .peer_clr(peer_clr), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wr_bit0(reg_wdata[0]), .log_q(log_q),
  .scrub_q(scrub_q), .rd_q(rd_q), .alt_q(alt_q), .dbl_q(dbl_q),
  .addr_q(addr_q)
);

// File: tb/ecc_err_logger_test.sv
module ecc_err_logger_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sb_err = 0, db_err = 0, ctx_scrub = 0, ctx_rd = 0, ctx_main = 0;
  logic [7:0] ctx_addr = '0;
  logic       peer_clr = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecc_err_logger uut (
    .clk(clk), .rst(rst), .sb_err(sb_err), .db_err(db_err),
    .ctx_scrub(ctx_scrub), .ctx_rd(ctx_rd), .ctx_main(ctx_main),
    .ctx_addr(ctx_addr), .peer_clr(peer_clr), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic set_event(input logic sb, input logic db, input logic scr,
                           input logic r, input logic mm, input logic [7:0] ad);
    sb_err = sb; db_err = db; ctx_scrub = scr; ctx_rd = r; ctx_main = mm; ctx_addr = ad;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
    sb_err = 0; db_err = 0; reg_wr = 0; peer_clr = 0;
  endtask

  task automatic pulse(input logic sb, input logic db, input logic scr,
                       input logic r, input logic mm, input logic [7:0] ad);
    set_event(sb, db, scr, r, mm, ad);
    step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic t_reset;
    expect_reg("R1 status", 2'd0, 8'h00);
    expect_reg("R1 addr", 2'd1, 8'h00);
  endtask

  task automatic t_cpu_single;
    wr(2'd0, 8'hFF);
    expect_reg("R2 write cannot set", 2'd0, 8'h00);
    pulse(1, 0, 0, 1, 1, 8'hA5);
    expect_reg("R5 R6 R7 R11 cpu single", 2'd0, 8'h05);
    expect_reg("R8 addr", 2'd1, 8'hA5);
  endtask

  task automatic t_freeze;
    pulse(0, 1, 1, 0, 0, 8'h3C);
    expect_reg("R4 status frozen", 2'd0, 8'h05);
    expect_reg("R4 addr frozen", 2'd1, 8'hA5);
    wr(2'd1, 8'hFF);
    expect_reg("R8 addr read-only", 2'd1, 8'hA5);
    wr(2'd0, 8'hFE);
    expect_reg("R3 write zero keeps", 2'd0, 8'h05);
  endtask

  task automatic t_clear;
    wr(2'd0, 8'h01);
    expect_reg("R3 cleared, fields kept", 2'd0, 8'h04);
    expect_reg("R3 addr kept", 2'd1, 8'hA5);
  endtask

  task automatic t_scrub_double;
    pulse(0, 1, 1, 1, 0, 8'h3C);
    expect_reg("R5 R6 R7 R11 scrub double", 2'd0, 8'h1B);
    expect_reg("R8 addr scrub", 2'd1, 8'h3C);
    peer_clr = 1;
    step();
    expect_reg("R9 peer clear", 2'd0, 8'h1A);
  endtask

  task automatic t_both;
    pulse(1, 1, 0, 0, 1, 8'h81);
    expect_reg("R11 both strobes", 2'd0, 8'h11);
    expect_reg("R8 addr both", 2'd1, 8'h81);
    wr(2'd0, 8'h01);
    expect_reg("R3 clear again", 2'd0, 8'h10);
  endtask

  task automatic t_collide;
    set_event(1, 0, 0, 1, 0, 8'h55);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h01;
    step();
    expect_reg("R10 write clear wins", 2'd0, 8'h10);
    expect_reg("R10 addr untouched", 2'd1, 8'h81);
    set_event(0, 1, 1, 0, 1, 8'h66);
    peer_clr = 1;
    step();
    expect_reg("R10 peer clear wins", 2'd0, 8'h10);
    pulse(1, 0, 0, 0, 0, 8'h77);
    expect_reg("R10 next event logs", 2'd0, 8'h09);
    expect_reg("R10 next addr", 2'd1, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_cpu_single();
    t_freeze();
    t_clear();
    t_scrub_double();
    t_both();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule